// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block lets an external serial master configure and inspect a measurement subsystem over a four-wire serial bus working in mode 0 (clock idles low, data sampled on the rising edge, shifted on the falling edge) with 16-bit frames. The chip-select, clock and data-in pins are brought into the system clock domain by a synchronizer, and every edge is found by comparing successive samples. The system clock must therefore be well above twice the serial clock rate. Each frame starts with a header byte and ends with a data byte. The header's top bit selects write (1) or read (0), and its low seven bits are the register address.

Writable registers hold the source select, the per-source enable, the gate length, the prescale code, mode enables, a second-source select and the two monitor bounds. A command register produces single-cycle start and history-clear pulses and holds a done-clear level. Read-only addresses return live status, count, random and history values that the measurement blocks supply on plain input ports. All configuration leaves the block on plain output ports.

Top module: `ctl_spi_regs`

## Requirements
- R1: Bits are sent MSB first, are sampled on rising serial clock edges while chip select is low, and form a header byte (bit 7 = 1 for write, 0 for read; bits 6:0 = address) followed by a data byte.
- R2: After reset the per-source enable reads 0x1F, the prescale code reads 1 (the divide-by-16 setting; 0/1/2/3 = divide by 8/16/32/64), the command pulses are low, and every other writable field is 0.
- R3: A write takes effect only when chip select rises after exactly 16 rising clock edges. A frame with fewer or more edges leaves every register unchanged.
- R4: During a read, the addressed register's byte is driven on MISO, MSB first, for the second byte. Each bit changes after a falling serial clock edge, so the master samples it on the next rising edge.
- R5: MISO is 0 while chip select is high, during the header byte, and throughout a write frame.
- R6: Writing 1 to bit 0 of address 0x00 gives exactly one system-cycle pulse on gate_start_o. Writing 1 to bit 2 gives exactly one such pulse on hist_clr_o. Both bits read back as 0.
- R7: Bit 1 of address 0x00 is stored, drives done_clr_o and reads back.
- R8: Read-only addresses return input values. 0x06 = {5'b0, done_i, ovf_i, busy_i}. 0x07 and 0x08 = count_i low and high byte. 0x0D = rand_i. 0x0E = {3'b0, mon_stat_i}. 0x0F = {3'b0, hist_stuck_i}. 0x10 = {3'b0, hist_low_i}. Writes to these addresses change no output.
- R9: Fields are masked to their width: 0x01 bits 2:0, 0x02 bits 4:0, 0x05 bits 1:0, 0x09 bits 2:0 and 0x0A bits 2:0. Unused bits read 0. Unmapped addresses read 0 and ignore writes.
- R10: 0x03 and 0x04 form gate_len_o {high, low}. 0x0B and 0x0C drive mon_lo_o and mon_hi_o. 0x09 bits 0, 1 and 2 drive rand_en_o, mon_en_o and diff_en_o. 0x01 drives src_sel_o and 0x0A drives src_b_sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| busy_i | input | 1 | Gate timer active status |
| ovf_i | input | 1 | Counter overflow status |
| done_i | input | 1 | Measurement done status |
| count_i | input | 16 | Latched count |
| rand_i | input | 8 | Random byte |
| mon_stat_i | input | 5 | Monitor status |
| hist_stuck_i | input | 5 | Per-source stuck history |
| hist_low_i | input | 5 | Per-source below-bound history |
| gate_start_o | output | 1 | Gate start pulse |
| hist_clr_o | output | 1 | History clear pulse |
| done_clr_o | output | 1 | Done clear level |
| src_sel_o | output | 3 | Primary source select |
| src_en_o | output | 5 | Per-source enable |
| gate_len_o | output | 16 | Gate length |
| prescale_o | output | 2 | Prescale code |
| rand_en_o | output | 1 | Random collection enable |
| mon_en_o | output | 1 | Monitor enable |
| diff_en_o | output | 1 | Differential mode enable |
| src_b_sel_o | output | 3 | Second source select |
| mon_lo_o | output | 8 | Monitor lower bound |
| mon_hi_o | output | 8 | Monitor upper bound |

## Verification
Frames with alternating and all-ones data patterns are read back from every writable register. This separates bit-order and field-mask faults from address-decode faults. Frames cut short at 12 edges and stretched to 17 edges must leave state untouched, which checks that the commit depends on the exact edge count. Read-only addresses are read with distinct input values so that a swapped mux leg is caught. Command writes are counted at the pulse outputs to tell a single-cycle pulse from a held or repeated one.

// File: rtl/ctl_spi_pkg.sv
package ctl_spi_pkg;
  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned HDR_BITS   = 8;
  localparam int unsigned ADDR_W     = 7;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned NUM_SRC    = 5;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned PRE_W      = 2;

  localparam logic [ADDR_W-1:0] A_CMD  = 7'h00;
  localparam logic [ADDR_W-1:0] A_SRC  = 7'h01;
  localparam logic [ADDR_W-1:0] A_EN   = 7'h02;
  localparam logic [ADDR_W-1:0] A_GLO  = 7'h03;
  localparam logic [ADDR_W-1:0] A_GHI  = 7'h04;
  localparam logic [ADDR_W-1:0] A_PRE  = 7'h05;
  localparam logic [ADDR_W-1:0] A_STAT = 7'h06;
  localparam logic [ADDR_W-1:0] A_CNTL = 7'h07;
  localparam logic [ADDR_W-1:0] A_CNTH = 7'h08;
  localparam logic [ADDR_W-1:0] A_MODE = 7'h09;
  localparam logic [ADDR_W-1:0] A_SRCB = 7'h0A;
  localparam logic [ADDR_W-1:0] A_MLO  = 7'h0B;
  localparam logic [ADDR_W-1:0] A_MHI  = 7'h0C;
  localparam logic [ADDR_W-1:0] A_RND  = 7'h0D;
  localparam logic [ADDR_W-1:0] A_MST  = 7'h0E;
  localparam logic [ADDR_W-1:0] A_HSTK = 7'h0F;
  localparam logic [ADDR_W-1:0] A_HLOW = 7'h10;

  typedef struct packed {
    logic                 done_clr;
    logic [SEL_W-1:0]     src_sel;
    logic [NUM_SRC-1:0]   src_en;
    logic [2*DATA_W-1:0]  gate_len;
    logic [PRE_W-1:0]     prescale;
    logic                 rand_en;
    logic                 mon_en;
    logic                 diff_en;
    logic [SEL_W-1:0]     src_b_sel;
    logic [DATA_W-1:0]    mon_lo;
    logic [DATA_W-1:0]    mon_hi;
  } cfg_t;
endpackage

// File: rtl/ctl_spi_sync.sv
module ctl_spi_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ctl_spi_frame.sv
module ctl_spi_frame
  import ctl_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_s_i,
  input  logic              cs_n_s_i,
  input  logic              mosi_s_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              miso_o
);
  localparam int unsigned CNT_MAX = FRAME_BITS + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_D0   = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_MAX);

  logic             sck_d_q, cs_d_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [DATA_W-1:0] sh_q, tx_q, hdr_q;
  logic             wr_q, miso_q;

  wire sck_rise = sck_s_i & ~sck_d_q;
  wire sck_fall = ~sck_s_i & sck_d_q;
  wire cs_fall  = ~cs_n_s_i & cs_d_q;
  wire cs_rise  = cs_n_s_i & ~cs_d_q;
  wire hdr_wr   = hdr_q[DATA_W-1];

  // address as it completes on the 8th rising edge
  assign rd_addr_o = {sh_q[ADDR_W-2:0], mosi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q   <= 1'b0;
      cs_d_q    <= 1'b1;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      hdr_q     <= '0;
      wr_q      <= 1'b0;
      miso_q    <= 1'b0;
    end else begin
      sck_d_q <= sck_s_i;
      cs_d_q  <= cs_n_s_i;
      wr_q    <= 1'b0;
      if (cs_fall) begin
        bit_cnt_q <= '0;
        miso_q    <= 1'b0;
      end else if (cs_n_s_i) begin
        miso_q <= 1'b0;
        if (cs_rise && bit_cnt_q == CNT_FULL && hdr_wr) wr_q <= 1'b1;
      end else begin
        if (sck_rise) begin
          sh_q <= {sh_q[DATA_W-2:0], mosi_s_i};
          if (bit_cnt_q != CNT_SAT) bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == CNT_HDR) begin
            hdr_q <= {sh_q[DATA_W-2:0], mosi_s_i};
            tx_q  <= rd_data_i;
          end
        end
        if (sck_fall) begin
          if (bit_cnt_q >= CNT_D0 && bit_cnt_q < CNT_FULL && !hdr_wr) begin
            miso_q <= tx_q[DATA_W-1];
            tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
          end else begin
            miso_q <= 1'b0;
          end
        end
      end
    end
  end

  assign wr_o      = wr_q;
  assign wr_addr_o = hdr_q[ADDR_W-1:0];
  assign wr_data_o = sh_q;
  assign miso_o    = miso_q;

  a_r5_miso_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_n_s_i) |-> !miso_o);
  a_r3_commit_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(cs_n_s_i));
  a_r3_commit_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);
endmodule

// File: rtl/ctl_spi_bank.sv
module ctl_spi_bank
  import ctl_spi_pkg::*;
#(
  parameter logic [NUM_SRC-1:0] EN_RESET  = '1,
  parameter logic [PRE_W-1:0]   PRE_RESET = 2'd1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic                busy_i,
  input  logic                ovf_i,
  input  logic                done_i,
  input  logic [2*DATA_W-1:0] count_i,
  input  logic [DATA_W-1:0]   rand_i,
  input  logic [NUM_SRC-1:0]  mon_stat_i,
  input  logic [NUM_SRC-1:0]  hist_stuck_i,
  input  logic [NUM_SRC-1:0]  hist_low_i,
  output cfg_t                cfg_o,
  output logic                gate_start_o,
  output logic                hist_clr_o,
  output logic [DATA_W-1:0]   rd_data_o
);
  localparam int unsigned SRC_PAD = DATA_W - NUM_SRC;
  localparam int unsigned SEL_PAD = DATA_W - SEL_W;
  localparam int unsigned PRE_PAD = DATA_W - PRE_W;

  cfg_t cfg_q;
  logic start_q, hclr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q          <= '0;
      cfg_q.src_en   <= EN_RESET;
      cfg_q.prescale <= PRE_RESET;
      start_q        <= 1'b0;
      hclr_q         <= 1'b0;
    end else begin
      start_q <= 1'b0;
      hclr_q  <= 1'b0;
      if (wr_i) begin
        unique case (wr_addr_i)
          A_CMD: begin
            start_q        <= wr_data_i[0];
            cfg_q.done_clr <= wr_data_i[1];
            hclr_q         <= wr_data_i[2];
          end
          A_SRC:  cfg_q.src_sel   <= wr_data_i[SEL_W-1:0];
          A_EN:   cfg_q.src_en    <= wr_data_i[NUM_SRC-1:0];
          A_GLO:  cfg_q.gate_len[DATA_W-1:0] <= wr_data_i;
          A_GHI:  cfg_q.gate_len[2*DATA_W-1:DATA_W] <= wr_data_i;
          A_PRE:  cfg_q.prescale  <= wr_data_i[PRE_W-1:0];
          A_MODE: begin
            cfg_q.rand_en <= wr_data_i[0];
            cfg_q.mon_en  <= wr_data_i[1];
            cfg_q.diff_en <= wr_data_i[2];
          end
          A_SRCB: cfg_q.src_b_sel <= wr_data_i[SEL_W-1:0];
          A_MLO:  cfg_q.mon_lo    <= wr_data_i;
          A_MHI:  cfg_q.mon_hi    <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      A_CMD:  rd_data_o = {6'b0, cfg_q.done_clr, 1'b0};
      A_SRC:  rd_data_o = {{SEL_PAD{1'b0}}, cfg_q.src_sel};
      A_EN:   rd_data_o = {{SRC_PAD{1'b0}}, cfg_q.src_en};
      A_GLO:  rd_data_o = cfg_q.gate_len[DATA_W-1:0];
      A_GHI:  rd_data_o = cfg_q.gate_len[2*DATA_W-1:DATA_W];
      A_PRE:  rd_data_o = {{PRE_PAD{1'b0}}, cfg_q.prescale};
      A_STAT: rd_data_o = {5'b0, done_i, ovf_i, busy_i};
      A_CNTL: rd_data_o = count_i[DATA_W-1:0];
      A_CNTH: rd_data_o = count_i[2*DATA_W-1:DATA_W];
      A_MODE: rd_data_o = {5'b0, cfg_q.diff_en, cfg_q.mon_en, cfg_q.rand_en};
      A_SRCB: rd_data_o = {{SEL_PAD{1'b0}}, cfg_q.src_b_sel};
      A_MLO:  rd_data_o = cfg_q.mon_lo;
      A_MHI:  rd_data_o = cfg_q.mon_hi;
      A_RND:  rd_data_o = rand_i;
      A_MST:  rd_data_o = {{SRC_PAD{1'b0}}, mon_stat_i};
      A_HSTK: rd_data_o = {{SRC_PAD{1'b0}}, hist_stuck_i};
      A_HLOW: rd_data_o = {{SRC_PAD{1'b0}}, hist_low_i};
      default: rd_data_o = '0;
    endcase
  end

  assign cfg_o        = cfg_q;
  assign gate_start_o = start_q;
  assign hist_clr_o   = hclr_q;

  a_r6_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_start_o |=> !gate_start_o);
  a_r6_hclr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_clr_o |=> !hist_clr_o);
  a_r3_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(cfg_q));
  a_r6_pulse_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_start_o |-> $past(wr_i));
endmodule

// File: rtl/ctl_spi_regs.sv
module ctl_spi_regs
  import ctl_spi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                cs_ni,
  input  logic                mosi_i,
  output logic                miso_o,
  input  logic                busy_i,
  input  logic                ovf_i,
  input  logic                done_i,
  input  logic [15:0]         count_i,
  input  logic [7:0]          rand_i,
  input  logic [4:0]          mon_stat_i,
  input  logic [4:0]          hist_stuck_i,
  input  logic [4:0]          hist_low_i,
  output logic                gate_start_o,
  output logic                hist_clr_o,
  output logic                done_clr_o,
  output logic [2:0]          src_sel_o,
  output logic [4:0]          src_en_o,
  output logic [15:0]         gate_len_o,
  output logic [1:0]          prescale_o,
  output logic                rand_en_o,
  output logic                mon_en_o,
  output logic                diff_en_o,
  output logic [2:0]          src_b_sel_o,
  output logic [7:0]          mon_lo_o,
  output logic [7:0]          mon_hi_o
);
  logic [2:0] pins_s;
  logic              wr;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  cfg_t              cfg;

  ctl_spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mosi_i, cs_ni, sck_i}),
    .q_o   (pins_s)
  );

  ctl_spi_frame i_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_s_i  (pins_s[0]),
    .cs_n_s_i (pins_s[1]),
    .mosi_s_i (pins_s[2]),
    .rd_data_i(rd_data),
    .rd_addr_o(rd_addr),
    .wr_o     (wr),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .miso_o   (miso_o)
  );

  ctl_spi_bank i_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_addr_i   (rd_addr),
    .busy_i      (busy_i),
    .ovf_i       (ovf_i),
    .done_i      (done_i),
    .count_i     (count_i),
    .rand_i      (rand_i),
    .mon_stat_i  (mon_stat_i),
    .hist_stuck_i(hist_stuck_i),
    .hist_low_i  (hist_low_i),
    .cfg_o       (cfg),
    .gate_start_o(gate_start_o),
    .hist_clr_o  (hist_clr_o),
    .rd_data_o   (rd_data)
  );

  assign done_clr_o  = cfg.done_clr;
  assign src_sel_o   = cfg.src_sel;
  assign src_en_o    = cfg.src_en;
  assign gate_len_o  = cfg.gate_len;
  assign prescale_o  = cfg.prescale;
  assign rand_en_o   = cfg.rand_en;
  assign mon_en_o    = cfg.mon_en;
  assign diff_en_o   = cfg.diff_en;
  assign src_b_sel_o = cfg.src_b_sel;
  assign mon_lo_o    = cfg.mon_lo;
  assign mon_hi_o    = cfg.mon_hi;
endmodule

// File: tb/test_ctl_spi_regs.sv
module test_ctl_spi_regs;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic busy = 0, ovf = 0, done = 0;
  logic [15:0] count = '0;
  logic [7:0]  rnd = '0;
  logic [4:0]  mst = '0, hstk = '0, hlow = '0;
  logic gate_start, hist_clr, done_clr, rand_en, mon_en, diff_en;
  logic [2:0] src_sel, src_b_sel;
  logic [4:0] src_en;
  logic [15:0] gate_len;
  logic [1:0] prescale;
  logic [7:0] mon_lo, mon_hi;

  int errors = 0, checks = 0;
  int start_cnt = 0, hclr_cnt = 0, wide_cnt = 0;
  logic start_d = 0, hclr_d = 0;

  always #10 clk = ~clk;

  ctl_spi_regs i_ctl_spi_regs (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .busy_i(busy), .ovf_i(ovf), .done_i(done), .count_i(count),
    .rand_i(rnd), .mon_stat_i(mst), .hist_stuck_i(hstk), .hist_low_i(hlow),
    .gate_start_o(gate_start), .hist_clr_o(hist_clr), .done_clr_o(done_clr),
    .src_sel_o(src_sel), .src_en_o(src_en), .gate_len_o(gate_len),
    .prescale_o(prescale), .rand_en_o(rand_en), .mon_en_o(mon_en),
    .diff_en_o(diff_en), .src_b_sel_o(src_b_sel), .mon_lo_o(mon_lo), .mon_hi_o(mon_hi)
  );

  always @(posedge clk) begin
    if (gate_start) start_cnt++;
    if (hist_clr) hclr_cnt++;
    if ((gate_start && start_d) || (hist_clr && hclr_d)) wide_cnt++;
    start_d <= gate_start;
    hclr_d  <= hist_clr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // send nbits of frame, MSB first; returns bits seen on MISO at rising edges
  task automatic xfer(input int nbits, input logic [31:0] frame, output logic [31:0] rx);
    rx = '0;
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      mosi = frame[i];
      wait_clk(HALF);
      sck = 1'b1;
      rx = {rx[30:0], miso};
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
    logic [31:0] rx;
    xfer(16, {16'h0, 1'b1, a, d}, rx);
    chk("R5 miso zero during write", rx, 0);
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [7:0] d);
    logic [31:0] rx;
    xfer(16, {16'h0, 1'b0, a, 8'h00}, rx);
    chk("R5 miso zero in header", {24'h0, rx[15:8]}, 0);
    d = rx[7:0];
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R2 src_en reset", src_en, 5'h1F);
    chk("R2 prescale reset", prescale, 2'd1);
    chk("R2 pulses low", {gate_start, hist_clr, done_clr}, 0);
    chk("R2 other fields zero", {src_sel, gate_len, rand_en, mon_en, diff_en, src_b_sel, mon_lo, mon_hi}, 0);
    chk("R5 miso idle", miso, 0);
    rd_reg(7'h02, d); chk("R2 R4 read en reset", d, 8'h1F);
    rd_reg(7'h05, d); chk("R2 R4 read prescale reset", d, 8'h01);
  endtask

  task automatic t_roundtrip;
    logic [7:0] d;
    wr_reg(7'h03, 8'hA5); wr_reg(7'h04, 8'h5A);
    chk("R10 gate_len", gate_len, 16'h5AA5);
    rd_reg(7'h03, d); chk("R1 R4 gate low readback", d, 8'hA5);
    rd_reg(7'h04, d); chk("R1 R4 gate high readback", d, 8'h5A);
    wr_reg(7'h0B, 8'h3C); wr_reg(7'h0C, 8'hC3);
    chk("R10 mon bounds", {mon_lo, mon_hi}, 16'h3CC3);
    rd_reg(7'h0C, d); chk("R4 mon_hi readback", d, 8'hC3);
    wr_reg(7'h09, 8'h05);
    chk("R10 mode bits", {diff_en, mon_en, rand_en}, 3'b101);
    wr_reg(7'h01, 8'h06); wr_reg(7'h0A, 8'h03);
    chk("R10 selects", {src_sel, src_b_sel}, 6'o63);
  endtask

  task automatic t_masks;
    logic [7:0] d;
    wr_reg(7'h01, 8'hFF); rd_reg(7'h01, d); chk("R9 src mask", d, 8'h07);
    wr_reg(7'h02, 8'hEA); rd_reg(7'h02, d); chk("R9 en mask", d, 8'h0A);
    chk("R9 en output", src_en, 5'h0A);
    wr_reg(7'h05, 8'hFE); rd_reg(7'h05, d); chk("R9 prescale mask", d, 8'h02);
    wr_reg(7'h09, 8'hFA); rd_reg(7'h09, d); chk("R9 mode mask", d, 8'h02);
    wr_reg(7'h0A, 8'hFD); rd_reg(7'h0A, d); chk("R9 srcb mask", d, 8'h05);
    wr_reg(7'h55, 8'hFF); rd_reg(7'h55, d); chk("R9 unmapped reads zero", d, 8'h00);
    chk("R9 unmapped write no effect", {src_sel, src_en, prescale, src_b_sel, mon_lo}, {3'h7, 5'h0A, 2'h2, 3'h5, 8'h3C});
  endtask

  task automatic t_cmd;
    logic [7:0] d;
    int s0, h0;
    s0 = start_cnt; h0 = hclr_cnt;
    wr_reg(7'h00, 8'h01);
    chk("R6 one start pulse", start_cnt - s0, 1);
    chk("R6 no hist pulse", hclr_cnt - h0, 0);
    wr_reg(7'h00, 8'h04);
    chk("R6 one hist pulse", hclr_cnt - h0, 1);
    chk("R6 start unchanged", start_cnt - s0, 1);
    chk("R6 single cycle", wide_cnt, 0);
    wr_reg(7'h00, 8'h07);
    chk("R7 done_clr level", done_clr, 1);
    chk("R6 both pulse", {32'(start_cnt - s0), 32'(hclr_cnt - h0)} == {32'd2, 32'd2}, 1);
    rd_reg(7'h00, d); chk("R6 R7 cmd readback", d, 8'h02);
    wr_reg(7'h00, 8'h00);
    chk("R7 done_clr cleared", done_clr, 0);
  endtask

  task automatic t_partial;
    logic [31:0] rx;
    logic [7:0] d;
    xfer(12, {20'h0, 1'b1, 7'h0B, 4'hF}, rx);
    chk("R3 short frame ignored", mon_lo, 8'h3C);
    xfer(17, {15'h0, 1'b1, 7'h0B, 8'h11, 1'b1}, rx);
    chk("R3 long frame ignored", mon_lo, 8'h3C);
    rd_reg(7'h0B, d); chk("R3 readback after bad frames", d, 8'h3C);
    wr_reg(7'h0B, 8'h11); chk("R3 full frame commits", mon_lo, 8'h11);
  endtask

  task automatic t_readonly;
    logic [7:0] d;
    busy = 1; ovf = 0; done = 1; count = 16'hBEEF; rnd = 8'h69;
    mst = 5'h15; hstk = 5'h0C; hlow = 5'h13;
    rd_reg(7'h06, d); chk("R8 status", d, 8'h05);
    rd_reg(7'h07, d); chk("R8 count low", d, 8'hEF);
    rd_reg(7'h08, d); chk("R8 count high", d, 8'hBE);
    rd_reg(7'h0D, d); chk("R8 random", d, 8'h69);
    rd_reg(7'h0E, d); chk("R8 monitor status", d, 8'h15);
    rd_reg(7'h0F, d); chk("R8 stuck history", d, 8'h0C);
    rd_reg(7'h10, d); chk("R8 low history", d, 8'h13);
    wr_reg(7'h07, 8'h00); wr_reg(7'h0D, 8'h00); wr_reg(7'h06, 8'hFF);
    chk("R8 ro writes no effect", {done_clr, src_sel, src_en, gate_len, prescale, rand_en, mon_en, diff_en, src_b_sel, mon_lo, mon_hi},
        {1'b0, 3'h7, 5'h0A, 16'h5AA5, 2'h2, 3'b010, 3'h5, 8'h11, 8'hC3});
    chk("R8 ro writes no pulse", {gate_start, hist_clr}, 0);
    chk("R5 miso idle after frames", miso, 0);
  endtask

  initial begin
    fork
      begin
        wait_clk(12);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset;
        t_roundtrip;
        t_masks;
        t_cmd;
        t_partial;
        t_readonly;
      end
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule